// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block is the hardware state machine that runs after an address translation cache misses. It takes a virtual address together with the base of the first-level translation table and fetches the first-level descriptor over a simple word-read port. The two low bits of that descriptor select one of four outcomes. A fault or a 1 MB section finishes the walk after a single read. A coarse or fine table pointer leads to a second read of a page descriptor.

The second-level descriptor either maps a 64 KB, 4 KB or 1 KB page or signals a fault. On success the walker gives the translation cache a physical base address, a two-bit page-size code and an 8-bit permission field, shown by a one-cycle `done_o` pulse. On failure it raises a one-cycle `fault_o` pulse and reports the table level that failed. The walker accepts one walk at a time and returns to idle in the cycle after either pulse.

Top module: `table_walker`

## Requirements
- R1: After reset and between walks, `req_ready_o` is 1 and `mem_req_o`, `done_o` and `fault_o` are 0.
- R2: The first read goes to address {ttb_i[31:14], va_i[31:20], 2'b00}.
- R3: A first-level descriptor with bits[1:0]=00 ends the walk with `fault_o`, `fault_level_o`=0 and no second read.
- R4: A first-level descriptor with bits[1:0]=10 ends the walk after one read with `fill_pa_o`={desc[31:20], 20'b0}, `fill_size_o`=00 and `fill_perm_o` holding desc[11:10] repeated four times.
- R5: A first-level descriptor with bits[1:0]=01 (coarse pointer) causes a second read at {desc[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with bits[1:0]=11 (fine pointer) causes a second read at {desc[31:12], va[19:10], 2'b00}.
- R7: A second-level descriptor with bits[1:0]=01 gives `fill_pa_o`={desc[31:16], 16'b0}, `fill_size_o`=01 and `fill_perm_o`=desc[11:4].
- R8: A second-level descriptor with bits[1:0]=10 gives `fill_pa_o`={desc[31:12], 12'b0}, `fill_size_o`=10 and `fill_perm_o`=desc[11:4].
- R9: A second-level descriptor with bits[1:0]=11 read from a fine table gives `fill_pa_o`={desc[31:10], 10'b0}, `fill_size_o`=11 and `fill_perm_o` holding desc[5:4] repeated four times.
- R10: A second-level descriptor with bits[1:0]=00, or with bits[1:0]=11 read from a coarse table, ends the walk with `fault_o` and `fault_level_o`=1.
- R11: `done_o` and `fault_o` are never high together. Each lasts one cycle, and `req_ready_o` is 1 in the next cycle.
- R12: A memory request stays asserted with a stable address until `mem_gnt_i`. Read data is taken only on `mem_rvalid_i`, so grant and response stalls do not change the result.
- R13: A `req_valid_i` raised while a walk is in progress is ignored. The result and read addresses belong to the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk (taken when ready) |
| req_ready_o | output | 1 | Walker idle and able to accept |
| va_i | input | 32 | Virtual address to translate |
| ttb_i | input | 32 | First-level table base (16 KB aligned) |
| mem_req_o | output | 1 | Word read request |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_addr_o | output | 32 | Word read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (descriptor) |
| done_o | output | 1 | One-cycle successful result pulse |
| fault_o | output | 1 | One-cycle translation fault pulse |
| fault_level_o | output | 1 | Level that faulted: 0 first, 1 second |
| fill_pa_o | output | 32 | Physical base of the mapped region |
| fill_size_o | output | 2 | 00 1 MB, 01 64 KB, 10 4 KB, 11 1 KB |
| fill_perm_o | output | 8 | Permission bits, two per subpage |

## Verification
The bench aims at the choice between one read and two reads. A design that misreads the type bits would issue a stray second read after a section or fault, or stop early after a pointer. Coarse and fine tables differ only in their index width and base alignment, so swapping them shows up as a wrong second-read address. A tiny-page code found in a coarse table must fault, and a design that treated it as a valid page would report a 1 KB mapping instead. Grant and response stalls, plus a new request raised mid-walk, expose a design that drops its address while waiting or that reloads its inputs while busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW        = 32;
  localparam int PERM_W    = 8;
  localparam int TTB_LSB   = 14;
  localparam int VA_LSB    = 10;
  localparam int L1_SHIFT  = 20;
  localparam int LG_SHIFT  = 16;
  localparam int SM_SHIFT  = 12;
  localparam int TN_SHIFT  = 10;

  typedef enum logic [1:0] {
    L1_FAULT   = 2'b00,
    L1_COARSE  = 2'b01,
    L1_SECTION = 2'b10,
    L1_FINE    = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    SZ_SECTION = 2'b00,
    SZ_LARGE   = 2'b01,
    SZ_SMALL   = 2'b10,
    SZ_TINY    = 2'b11
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic [AW-1:0]     pa;
    size_e             size;
    logic [PERM_W-1:0] perm;
    logic              fault;
    logic              level;
  } walk_res_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [AW-1:TTB_LSB] ttb_hi_i,
  input  logic [AW-1:VA_LSB]  va_hi_i,
  input  logic [AW-1:0]       ptr_i,
  input  logic                fine_i,
  output logic [AW-1:0]       l1_addr_o,
  output logic [AW-1:0]       l2_addr_o
);
  logic [AW-1:0] coarse_addr, fine_addr;

  assign l1_addr_o   = {ttb_hi_i, va_hi_i[AW-1:L1_SHIFT], 2'b00};
  // coarse: 256 entries, 1 KB aligned; fine: 1024 entries, 4 KB aligned
  assign coarse_addr = {ptr_i[AW-1:10], va_hi_i[19:12], 2'b00};
  assign fine_addr   = {ptr_i[AW-1:12], va_hi_i[19:10], 2'b00};
  assign l2_addr_o   = fine_i ? fine_addr : coarse_addr;

  logic unused_ptr;
  assign unused_ptr = ^ptr_i[9:0];
endmodule

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [AW-1:0] desc_i,
  output l1_kind_e      kind_o,
  output walk_res_t     res_o
);
  assign kind_o = l1_kind_e'(desc_i[1:0]);

  always_comb begin
    res_o       = '0;
    res_o.level = 1'b0;
    if (kind_o == L1_SECTION) begin
      res_o.pa   = {desc_i[AW-1:L1_SHIFT], {L1_SHIFT{1'b0}}};
      res_o.size = SZ_SECTION;
      res_o.perm = {4{desc_i[11:10]}};
    end else begin
      res_o.fault = 1'b1;
    end
  end

  logic unused_desc;
  assign unused_desc = ^{desc_i[19:12], desc_i[9:2]};
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [AW-1:0] desc_i,
  input  logic          fine_i,
  output walk_res_t     res_o
);
  always_comb begin
    res_o       = '0;
    res_o.level = 1'b1;
    unique case (desc_i[1:0])
      2'b01: begin
        res_o.pa   = {desc_i[AW-1:LG_SHIFT], {LG_SHIFT{1'b0}}};
        res_o.size = SZ_LARGE;
        res_o.perm = desc_i[11:4];
      end
      2'b10: begin
        res_o.pa   = {desc_i[AW-1:SM_SHIFT], {SM_SHIFT{1'b0}}};
        res_o.size = SZ_SMALL;
        res_o.perm = desc_i[11:4];
      end
      2'b11: begin
        // 1 KB entries exist only in fine tables
        if (fine_i) begin
          res_o.pa   = {desc_i[AW-1:TN_SHIFT], {TN_SHIFT{1'b0}}};
          res_o.size = SZ_TINY;
          res_o.perm = {4{desc_i[5:4]}};
        end else begin
          res_o.fault = 1'b1;
        end
      end
      default: res_o.fault = 1'b1;
    endcase
  end

  logic unused_desc;
  assign unused_desc = ^desc_i[3:2];
endmodule

// File: rtl/table_walker.sv
module table_walker
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [31:0]       va_i,
  input  logic [31:0]       ttb_i,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic              fault_level_o,
  output logic [31:0]       fill_pa_o,
  output logic [1:0]        fill_size_o,
  output logic [7:0]        fill_perm_o
);
  walk_state_e          state_q;
  logic [AW-1:VA_LSB]   va_q;
  logic [AW-1:TTB_LSB]  ttb_q;
  logic [AW-1:0]        ptr_q;
  logic                 fine_q;
  walk_res_t            res_q;

  logic [AW-1:0] l1_addr, l2_addr;
  l1_kind_e      l1_kind;
  walk_res_t     l1_res, l2_res;

  ptw_addr_gen u_addr (
    .ttb_hi_i  (ttb_q),
    .va_hi_i   (va_q),
    .ptr_i     (ptr_q),
    .fine_i    (fine_q),
    .l1_addr_o (l1_addr),
    .l2_addr_o (l2_addr)
  );

  ptw_l1_decode u_l1 (
    .desc_i (mem_rdata_i),
    .kind_o (l1_kind),
    .res_o  (l1_res)
  );

  ptw_l2_decode u_l2 (
    .desc_i (mem_rdata_i),
    .fine_i (fine_q),
    .res_o  (l2_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      ttb_q   <= '0;
      ptr_q   <= '0;
      fine_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= va_i[AW-1:VA_LSB];
          ttb_q   <= ttb_i[AW-1:TTB_LSB];
          state_q <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_gnt_i) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rvalid_i) begin
          if (l1_kind == L1_COARSE || l1_kind == L1_FINE) begin
            ptr_q   <= mem_rdata_i;
            fine_q  <= (l1_kind == L1_FINE);
            state_q <= ST_L2_REQ;
          end else begin
            res_q   <= l1_res;
            state_q <= ST_DONE;
          end
        end
        ST_L2_REQ: if (mem_gnt_i) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rvalid_i) begin
          res_q   <= l2_res;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign mem_req_o     = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o    = (state_q == ST_L1_REQ) ? l1_addr : l2_addr;
  assign done_o        = (state_q == ST_DONE) && !res_q.fault;
  assign fault_o       = (state_q == ST_DONE) && res_q.fault;
  assign fault_level_o = res_q.level;
  assign fill_pa_o     = res_q.pa;
  assign fill_size_o   = res_q.size;
  assign fill_perm_o   = res_q.perm;

  logic unused_in;
  assign unused_in = ^{va_i[VA_LSB-1:0], ttb_i[TTB_LSB-1:0]};
endmodule

// File: rtl/table_walker_checks.sv
module table_walker_checks (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        mem_req_o,
  input logic        mem_gnt_i,
  input logic [31:0] mem_addr_o,
  input logic        done_o,
  input logic        fault_o,
  input logic [31:0] fill_pa_o,
  input logic [1:0]  fill_size_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !done_o && !fault_o); // R1

  AST_SECTION_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fill_size_o == 2'b00) |-> fill_pa_o[19:0] == 20'd0); // R4

  AST_LARGE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fill_size_o == 2'b01) |-> fill_pa_o[15:0] == 16'd0); // R7

  AST_SMALL_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fill_size_o == 2'b10) |-> fill_pa_o[11:0] == 12'd0); // R8

  AST_TINY_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fill_size_o == 2'b11) |-> fill_pa_o[9:0] == 10'd0); // R9

  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o)); // R11

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> !done_o && !fault_o && req_ready_o); // R11

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> mem_req_o && $stable(mem_addr_o)); // R12
endmodule

bind table_walker table_walker_checks u_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_addr_o  (mem_addr_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .fill_pa_o   (fill_pa_o),
  .fill_size_o (fill_size_o)
);

// File: tb/table_walker_test.sv
`timescale 1ns/1ps
module table_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] va = '0, ttb = '0;
  logic        mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        done, fault, fault_level;
  logic [31:0] fill_pa;
  logic [1:0]  fill_size;
  logic [7:0]  fill_perm;

  always #2.5 clk = ~clk;

  table_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .va_i(va), .ttb_i(ttb), .mem_req_o(mem_req), .mem_gnt_i(mem_gnt),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .fault_level_o(fault_level),
    .fill_pa_o(fill_pa), .fill_size_o(fill_size), .fill_perm_o(fill_perm)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // memory responder: descriptors for first and second read, programmable stall
  logic [31:0] l1_word, l2_word, held_addr;
  logic [31:0] rd_addr [2];
  int nreads = 0, phase = 0, cnt = 0, stall = 0;

  always @(negedge clk) begin
    mem_gnt    = 1'b0;
    mem_rvalid = 1'b0;
    if (phase == 0 && mem_req) begin
      if (cnt == 0) held_addr = mem_addr;
      else check(mem_addr == held_addr, "R12 addr held during grant stall", mem_addr, held_addr);
      if (cnt >= stall) begin
        mem_gnt = 1'b1;
        if (nreads < 2) rd_addr[nreads] = mem_addr;
        phase = 1; cnt = 0;
      end else cnt++;
    end else if (phase == 1) begin
      if (cnt >= stall) begin
        mem_rvalid = 1'b1;
        mem_rdata  = (nreads == 0) ? l1_word : l2_word;
        nreads++;
        phase = 0; cnt = 0;
      end else begin
        mem_rdata = 32'hBAD0_BAD0;
        cnt++;
      end
    end
  end

  typedef struct packed {
    logic [31:0] va, ttb, l1, l2;
    logic [3:0]  stall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 32'h8000_4000, 32'hABC0_0C02, 32'h0,         4'd0}, // R4 section
    '{32'hFEDC_BA98, 32'h0001_C000, 32'hFFFF_FFFC, 32'h0,         4'd0}, // R3 L1 fault
    '{32'h0ABC_DEF0, 32'h4000_0000, 32'h0012_3401, 32'hDEAD_BE71, 4'd0}, // R5 R7 coarse large
    '{32'h7654_3210, 32'h1234_8000, 32'h0055_AC01, 32'h1357_9A5E, 4'd1}, // R5 R8 coarse small
    '{32'h3339_8765, 32'h0000_0000, 32'h4567_8FF3, 32'h2468_AC33, 4'd0}, // R6 R9 fine tiny
    '{32'h0000_FFFF, 32'hFFFF_C000, 32'h0000_0401, 32'hFFFF_FFF3, 4'd0}, // R10 tiny in coarse
    '{32'hC0DE_1234, 32'h2000_4000, 32'h3000_1003, 32'h1111_1110, 4'd0}, // R10 L2 fault
    '{32'h5A5A_5A5A, 32'hA5A5_8000, 32'h9990_2003, 32'h0F0F_F0F2, 4'd2}, // R6 R8 stalled
    '{32'hFFF0_0000, 32'h0000_C000, 32'hFFF0_0402, 32'h0,         4'd3}  // R4 R12 stalled
  };

  // reference model built from the requirement text
  typedef struct packed {
    logic [31:0] a1, a2, pa;
    logic [1:0]  size;
    logic [7:0]  perm;
    logic        is_fault, level;
    logic [1:0]  reads;
  } exp_t;

  function automatic exp_t model(input vec_t v);
    exp_t e = '0;
    logic fine;
    e.a1 = {v.ttb[31:14], v.va[31:20], 2'b00};
    e.reads = 2'd1;
    case (v.l1[1:0])
      2'b00: e.is_fault = 1'b1;
      2'b10: begin
        e.pa = v.l1 & 32'hFFF0_0000; e.size = 2'b00; e.perm = {4{v.l1[11:10]}};
      end
      default: begin
        fine = (v.l1[1:0] == 2'b11);
        e.reads = 2'd2; e.level = 1'b1;
        e.a2 = fine ? ((v.l1 & 32'hFFFF_F000) | (32'(v.va[19:10]) << 2))
                    : ((v.l1 & 32'hFFFF_FC00) | (32'(v.va[19:12]) << 2));
        case (v.l2[1:0])
          2'b01: begin e.pa = v.l2 & 32'hFFFF_0000; e.size = 2'b01; e.perm = v.l2[11:4]; end
          2'b10: begin e.pa = v.l2 & 32'hFFFF_F000; e.size = 2'b10; e.perm = v.l2[11:4]; end
          2'b11: if (fine) begin
                   e.pa = v.l2 & 32'hFFFF_FC00; e.size = 2'b11; e.perm = {4{v.l2[5:4]}};
                 end else e.is_fault = 1'b1;
          default: e.is_fault = 1'b1;
        endcase
      end
    endcase
    return e;
  endfunction

  task automatic launch(input vec_t v);
    @(negedge clk); #1;
    l1_word = v.l1; l2_word = v.l2; stall = int'(v.stall);
    nreads = 0; phase = 0; cnt = 0;
    rd_addr[0] = 'x; rd_addr[1] = 'x;
    va = v.va; ttb = v.ttb; req_valid = 1'b1;
    check(req_ready == 1'b1, "R1 ready before walk", 32'(req_ready), 32'd1);
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_walk(input vec_t v);
    exp_t e = model(v);
    int waited = 0;
    while (!(done || fault) && waited < 200) begin
      @(negedge clk); #1; waited++;
    end
    check(waited < 200, "R11 walk completes", 32'(waited), 32'd200);
    check(fault == e.is_fault && done == !e.is_fault, "R3 R10 result kind",
          {30'd0, done, fault}, {30'd0, !e.is_fault, e.is_fault});
    check(32'(nreads) == 32'(e.reads), "R3 R4 read count", 32'(nreads), 32'(e.reads));
    check(rd_addr[0] == e.a1, "R2 first read address", rd_addr[0], e.a1);
    if (e.reads == 2)
      check(rd_addr[1] == e.a2, "R5 R6 second read address", rd_addr[1], e.a2);
    if (e.is_fault) begin
      check(fault_level == e.level, "R3 R10 fault level", 32'(fault_level), 32'(e.level));
    end else begin
      check(fill_pa == e.pa, "R4 R7 R8 R9 physical base", fill_pa, e.pa);
      check(fill_size == e.size, "R4 R7 R8 R9 size code", 32'(fill_size), 32'(e.size));
      check(fill_perm == e.perm, "R4 R7 R8 R9 permissions", 32'(fill_perm), 32'(e.perm));
    end
    @(negedge clk); #1;
    check(!done && !fault && req_ready, "R11 single pulse then ready",
          {29'd0, done, fault, req_ready}, 32'd1);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(req_ready && !mem_req && !done && !fault, "R1 state in reset",
          {28'd0, req_ready, mem_req, done, fault}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(req_ready && !mem_req && !done && !fault, "R1 idle after reset",
          {28'd0, req_ready, mem_req, done, fault}, 32'h8);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      finish_walk(VECS[i]);
    end

    // R13: a new request raised mid-walk must be ignored
    begin
      vec_t v = '{32'h2340_0000, 32'h0000_4000, 32'h7770_0802, 32'h0, 4'd2};
      launch(v);
      check(req_ready == 1'b0, "R13 busy after accept", 32'(req_ready), 32'd0);
      va = 32'hFFF0_0000; ttb = 32'hFFFF_C000; req_valid = 1'b1;
      @(negedge clk); #1;
      @(negedge clk); #1;
      req_valid = 1'b0;
      finish_walk(v);
      check(nreads == 1, "R13 no extra walk from ignored request", 32'(nreads), 32'd1);
    end

    // R1: ready stays high and no read is issued while idle
    repeat (4) @(negedge clk);
    #1;
    check(req_ready && !mem_req, "R1 quiet while idle", {30'd0, req_ready, mem_req}, 32'h2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule